// File: doc/BRIEF.md
# Translation Buffer Invalidate Walker

This block keeps the tag side of a guest translation buffer and clears entries out of it by walking a range of slots one slot per clock. Each slot holds an address-space identifier, a global flag, a guest identifier and a hardware-invalid flag. The slots form two parts. A small fully associative part sits at the low indices. A set-associative part of fixed-size pages follows it. A separate configuration can instead treat all slots as one joint array.

Two commands start a walk. The selective command marks invalid every non-global slot whose identifier equals the supplied one. The flush command marks invalid every slot in range and does not look at the identifier or the global flag. When the guest-identifier filter is on, both commands touch only slots whose guest identifier equals the supplied root guest identifier. Three things pick the walked range: the buffer organisation, the walk mode (software-stepped or hardware-complete) and the command index. A write port loads tags, and a lookup port reads any slot back.

Top module: `tlb_inv_walk`

## Requirements
- R1: After reset, `busy` and `done` are 0, and every slot reads back with `lk_inv`=1 and zero tags.
- R2: While the walker is idle, a cycle with `wr_en`=1 stores the given identifier, global flag and guest identifier into slot `wr_idx` and clears that slot's invalid flag.
- R3: A selective walk (`cmd_flush`=0) sets the invalid flag of every in-range slot whose identifier equals `cmd_asid` and whose global flag is 0.
- R4: A selective walk leaves slots with global flag 1 unchanged.
- R5: A flush walk (`cmd_flush`=1) sets the invalid flag of every in-range slot, whatever its identifier or global flag.
- R6: With `gid_en`=1, either command changes only slots whose guest identifier equals `root_gid`.
- R7: With `cfg_split`=0 (joint array), every slot 0..TOTAL-1 is walked and `cmd_idx` has no effect.
- R8: With `cfg_split`=1 and `cfg_hw_walk`=0, an index below VAR_ENTRIES walks slots 0..VAR_ENTRIES-1 only.
- R9: With `cfg_split`=1 and `cfg_hw_walk`=0, an index at or above VAR_ENTRIES walks one set only. The set is s = (idx - VAR_ENTRIES) mod FT_SETS, and its slots are VAR_ENTRIES + s*FT_WAYS + w for w = 0..FT_WAYS-1.
- R10: With `cfg_split`=1 and `cfg_hw_walk`=1, every slot is walked and `cmd_idx` has no effect.
- R11: One slot is examined per cycle. `busy` is high for exactly as many cycles as the range has slots, starting the cycle after the command is taken. `done` is high for the single cycle after the last one.
- R12: While `busy` is high, `cmd_valid` and `wr_en` are ignored. The running walk and the stored tags do not change because of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_split | input | 1 | 1 = variable part plus set-associative part, 0 = joint array |
| cfg_hw_walk | input | 1 | 1 = one command walks everything, 0 = software-stepped |
| cmd_valid | input | 1 | Start a walk (taken only when idle) |
| cmd_flush | input | 1 | 1 = flush, 0 = identifier-selective |
| cmd_idx | input | IDX_W | Command index used for range choice |
| cmd_asid | input | ASID_W | Identifier to match |
| gid_en | input | 1 | Enable guest-identifier filter |
| root_gid | input | GID_W | Guest identifier to match |
| wr_en | input | 1 | Tag write strobe |
| wr_idx | input | IDX_W | Slot to write |
| wr_asid | input | ASID_W | Identifier to store |
| wr_glob | input | 1 | Global flag to store |
| wr_gid | input | GID_W | Guest identifier to store |
| lk_idx | input | IDX_W | Slot to read back |
| lk_inv | output | 1 | Invalid flag of slot `lk_idx` |
| lk_asid | output | ASID_W | Identifier of slot `lk_idx` |
| lk_glob | output | 1 | Global flag of slot `lk_idx` |
| lk_gid | output | GID_W | Guest identifier of slot `lk_idx` |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at walk end |

## Verification
A wrong range start or end shows up in two ways. The number of `busy` cycles differs from the size of the range, and at `done` slots just outside the range read back as invalid, or slots inside it read back as valid. A fault in the match logic leaves at least one slot with the wrong invalid flag when `done` pulses, and the lookup port sees this right away. If the controller took a command while busy, the walk length would change or the write made during the walk would appear in the tags. Either one is visible at the first readback after `done`.

// File: rtl/tiw_pkg.sv
package tiw_pkg;

    localparam int DEF_VAR_ENTRIES = 4;
    localparam int DEF_FT_SETS     = 4;
    localparam int DEF_FT_WAYS     = 2;
    localparam int DEF_ASID_W      = 8;
    localparam int DEF_GID_W       = 4;

    // Which part of the slot space a command covers
    typedef enum logic [1:0] {
        SPAN_ALL = 2'd0,
        SPAN_VAR = 2'd1,
        SPAN_SET = 2'd2
    } span_e;

    function automatic span_e choose_span(input logic split, input logic hw, input logic in_var);
        if (!split || hw) return SPAN_ALL;
        else if (in_var)  return SPAN_VAR;
        else              return SPAN_SET;
    endfunction

endpackage

// File: rtl/tiw_range.sv
module tiw_range
    import tiw_pkg::*;
#(
    parameter int VAR_ENTRIES = DEF_VAR_ENTRIES,
    parameter int FT_SETS     = DEF_FT_SETS,
    parameter int FT_WAYS     = DEF_FT_WAYS,
    parameter int IDX_W       = 4
)(
    input  logic             split,
    input  logic             hw,
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] first,
    output logic [IDX_W-1:0] last
);
    localparam int TOTAL = VAR_ENTRIES + FT_SETS * FT_WAYS;
    localparam logic [IDX_W-1:0] VAR_L  = IDX_W'(VAR_ENTRIES);
    localparam logic [IDX_W-1:0] SETS_L = IDX_W'(FT_SETS);
    localparam logic [IDX_W-1:0] WAYS_L = IDX_W'(FT_WAYS);

    logic             in_var;
    logic [IDX_W-1:0] off, set_sel, base;
    span_e            span;

    always_comb begin
        in_var  = idx < VAR_L;
        off     = idx - VAR_L;
        set_sel = off % SETS_L;
        base    = VAR_L + set_sel * WAYS_L;
        span    = choose_span(split, hw, in_var);
        case (span)
            SPAN_VAR: begin first = '0;   last = VAR_L - IDX_W'(1); end
            SPAN_SET: begin first = base; last = base + WAYS_L - IDX_W'(1); end
            default:  begin first = '0;   last = IDX_W'(TOTAL - 1); end
        endcase
    end
endmodule

// File: rtl/tiw_tags.sv
module tiw_tags #(
    parameter int N      = 12,
    parameter int ASID_W = 8,
    parameter int GID_W  = 4,
    parameter int IDX_W  = 4
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_glob,
    input  logic [GID_W-1:0]  wr_gid,
    input  logic              chk_en,
    input  logic [IDX_W-1:0]  chk_idx,
    input  logic              chk_flush,
    input  logic [ASID_W-1:0] chk_asid,
    input  logic              chk_gid_en,
    input  logic [GID_W-1:0]  chk_gid,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_inv,
    output logic [ASID_W-1:0] lk_asid,
    output logic              lk_glob,
    output logic [GID_W-1:0]  lk_gid
);
    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [GID_W-1:0]  gid;
        logic              inv;
    } tag_t;

    tag_t slot [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic sel_chk, sel_wr, hit;
        always_comb begin
            sel_chk = chk_en && (chk_idx == IDX_W'(g));
            sel_wr  = wr_en  && (wr_idx  == IDX_W'(g));
            hit     = chk_flush || ((slot[g].asid == chk_asid) && !slot[g].glob);
            if (chk_gid_en && (slot[g].gid != chk_gid)) hit = 1'b0;
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g] <= '{asid: '0, glob: 1'b0, gid: '0, inv: 1'b1};
            end else if (sel_wr) begin
                slot[g] <= '{asid: wr_asid, glob: wr_glob, gid: wr_gid, inv: 1'b0};
            end else if (sel_chk && hit) begin
                slot[g].inv <= 1'b1;
            end
        end
    end

    always_comb begin
        if (lk_idx < IDX_W'(N)) begin
            lk_inv  = slot[lk_idx].inv;
            lk_asid = slot[lk_idx].asid;
            lk_glob = slot[lk_idx].glob;
            lk_gid  = slot[lk_idx].gid;
        end else begin
            lk_inv  = 1'b1;
            lk_asid = '0;
            lk_glob = 1'b0;
            lk_gid  = '0;
        end
    end

    AST_GLOBAL_KEPT: assert property (@(posedge clk) disable iff (rst)
        (chk_en && !wr_en && !chk_flush && slot[chk_idx].glob && !slot[chk_idx].inv)
        |=> !slot[$past(chk_idx)].inv); // R4

    AST_GID_FILTER: assert property (@(posedge clk) disable iff (rst)
        (chk_en && !wr_en && chk_gid_en && (slot[chk_idx].gid != chk_gid) && !slot[chk_idx].inv)
        |=> !slot[$past(chk_idx)].inv); // R6

    AST_FLUSH_HITS: assert property (@(posedge clk) disable iff (rst)
        (chk_en && !wr_en && chk_flush && !chk_gid_en)
        |=> slot[$past(chk_idx)].inv); // R5
endmodule

// File: rtl/tiw_ctrl.sv
module tiw_ctrl #(
    parameter int N      = 12,
    parameter int ASID_W = 8,
    parameter int GID_W  = 4,
    parameter int IDX_W  = 4
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_flush,
    input  logic [ASID_W-1:0] cmd_asid,
    input  logic              gid_en,
    input  logic [GID_W-1:0]  root_gid,
    input  logic [IDX_W-1:0]  first,
    input  logic [IDX_W-1:0]  last,
    output logic              busy,
    output logic              done,
    output logic [IDX_W-1:0]  ptr,
    output logic              req_flush,
    output logic [ASID_W-1:0] req_asid,
    output logic              req_gid_en,
    output logic [GID_W-1:0]  req_gid
);
    typedef struct packed {
        logic              flush;
        logic [ASID_W-1:0] asid;
        logic              gid_en;
        logic [GID_W-1:0]  gid;
    } req_t;

    req_t             req_q;
    logic             busy_q, done_q;
    logic [IDX_W-1:0] ptr_q, last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            ptr_q  <= '0;
            last_q <= '0;
            req_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (cmd_valid) begin
                    busy_q <= 1'b1;
                    ptr_q  <= first;
                    last_q <= last;
                    req_q  <= '{flush: cmd_flush, asid: cmd_asid, gid_en: gid_en, gid: root_gid};
                end
            end else if (ptr_q == last_q) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                ptr_q <= ptr_q + IDX_W'(1);
            end
        end
    end

    assign busy       = busy_q;
    assign done       = done_q;
    assign ptr        = ptr_q;
    assign req_flush  = req_q.flush;
    assign req_asid   = req_q.asid;
    assign req_gid_en = req_q.gid_en;
    assign req_gid    = req_q.gid;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R11

    AST_DONE_AFTER_WALK: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!busy_q && $past(busy_q))); // R11

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> ((ptr_q <= last_q) && (last_q < IDX_W'(N)))); // R11

    AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cmd_valid) |=> ($stable(last_q) && $stable(req_q))); // R12
endmodule

// File: rtl/tlb_inv_walk.sv
module tlb_inv_walk
    import tiw_pkg::*;
#(
    parameter int VAR_ENTRIES = DEF_VAR_ENTRIES,
    parameter int FT_SETS     = DEF_FT_SETS,
    parameter int FT_WAYS     = DEF_FT_WAYS,
    parameter int ASID_W      = DEF_ASID_W,
    parameter int GID_W       = DEF_GID_W,
    localparam int TOTAL      = VAR_ENTRIES + FT_SETS * FT_WAYS,
    localparam int IDX_W      = $clog2(TOTAL)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_split,
    input  logic              cfg_hw_walk,
    input  logic              cmd_valid,
    input  logic              cmd_flush,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [ASID_W-1:0] cmd_asid,
    input  logic              gid_en,
    input  logic [GID_W-1:0]  root_gid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_glob,
    input  logic [GID_W-1:0]  wr_gid,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_inv,
    output logic [ASID_W-1:0] lk_asid,
    output logic              lk_glob,
    output logic [GID_W-1:0]  lk_gid,
    output logic              busy,
    output logic              done
);
    logic [IDX_W-1:0]  first, last, ptr;
    logic              req_flush, req_gid_en;
    logic [ASID_W-1:0] req_asid;
    logic [GID_W-1:0]  req_gid;
    logic              wr_ok;

    assign wr_ok = wr_en && !busy; // R12

    tiw_range #(.VAR_ENTRIES(VAR_ENTRIES), .FT_SETS(FT_SETS), .FT_WAYS(FT_WAYS), .IDX_W(IDX_W)) u_range (
        .split(cfg_split), .hw(cfg_hw_walk), .idx(cmd_idx), .first(first), .last(last)
    );

    tiw_ctrl #(.N(TOTAL), .ASID_W(ASID_W), .GID_W(GID_W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_flush(cmd_flush), .cmd_asid(cmd_asid),
        .gid_en(gid_en), .root_gid(root_gid), .first(first), .last(last),
        .busy(busy), .done(done), .ptr(ptr), .req_flush(req_flush), .req_asid(req_asid),
        .req_gid_en(req_gid_en), .req_gid(req_gid)
    );

    tiw_tags #(.N(TOTAL), .ASID_W(ASID_W), .GID_W(GID_W), .IDX_W(IDX_W)) u_tags (
        .clk(clk), .rst(rst), .wr_en(wr_ok), .wr_idx(wr_idx), .wr_asid(wr_asid),
        .wr_glob(wr_glob), .wr_gid(wr_gid), .chk_en(busy), .chk_idx(ptr),
        .chk_flush(req_flush), .chk_asid(req_asid), .chk_gid_en(req_gid_en), .chk_gid(req_gid),
        .lk_idx(lk_idx), .lk_inv(lk_inv), .lk_asid(lk_asid), .lk_glob(lk_glob), .lk_gid(lk_gid)
    );

    AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && (lk_idx == wr_idx)) |=> $stable(lk_asid) || !$stable(lk_idx)); // R12
endmodule

// File: tb/tlb_inv_walk_tb.sv
module tlb_inv_walk_tb;
    localparam int PERIOD = 10;
    localparam int VE = 4, NS = 4, NW = 2, AW = 8, GW = 4;
    localparam int TOT = VE + NS * NW;
    localparam int IW = $clog2(TOT);

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_split = 0, cfg_hw_walk = 0, cmd_valid = 0, cmd_flush = 0, gid_en = 0;
    logic [IW-1:0] cmd_idx = '0, wr_idx = '0, lk_idx = '0;
    logic [AW-1:0] cmd_asid = '0, wr_asid = '0;
    logic [GW-1:0] root_gid = '0, wr_gid = '0;
    logic wr_en = 0, wr_glob = 0;
    logic lk_inv, lk_glob, busy, done;
    logic [AW-1:0] lk_asid;
    logic [GW-1:0] lk_gid;

    int checks = 0, errors = 0;
    int m_asid [TOT];
    bit m_glob [TOT];
    int m_gid  [TOT];
    bit m_inv  [TOT];

    always #(PERIOD/2) clk = ~clk;

    tlb_inv_walk #(.VAR_ENTRIES(VE), .FT_SETS(NS), .FT_WAYS(NW), .ASID_W(AW), .GID_W(GW)) u_dut (
        .clk(clk), .rst(rst), .cfg_split(cfg_split), .cfg_hw_walk(cfg_hw_walk),
        .cmd_valid(cmd_valid), .cmd_flush(cmd_flush), .cmd_idx(cmd_idx), .cmd_asid(cmd_asid),
        .gid_en(gid_en), .root_gid(root_gid), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_asid(wr_asid), .wr_glob(wr_glob), .wr_gid(wr_gid), .lk_idx(lk_idx),
        .lk_inv(lk_inv), .lk_asid(lk_asid), .lk_glob(lk_glob), .lk_gid(lk_gid),
        .busy(busy), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input int r);
        for (int i = 0; i < TOT; i++) begin
            @(negedge clk);
            m_asid[i] = (i + r) % 4;
            m_glob[i] = ((i + r) % 5) == 0;
            m_gid[i]  = (i * 7 + r) % 3;
            m_inv[i]  = 1'b0;
            wr_en = 1; wr_idx = IW'(i); wr_asid = AW'(m_asid[i]);
            wr_glob = m_glob[i]; wr_gid = GW'(m_gid[i]);
        end
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic verify_all(input string req);
        for (int i = 0; i < TOT; i++) begin
            lk_idx = IW'(i);
            #1;
            check({req, " inv"},  int'(lk_inv),  int'(m_inv[i]));
            check({req, " asid"}, int'(lk_asid), m_asid[i]);
            check({req, " glob"}, int'(lk_glob), int'(m_glob[i]));
            check({req, " gid"},  int'(lk_gid),  m_gid[i]);
        end
    endtask

    task automatic run(input bit sp, input bit hw, input int idx, input bit fl, input int r);
        int lo, hi, cnt, s;
        bit gen;
        int ca, rg;
        string rtag, mtag;
        gen = (idx % 3) == 0;
        ca  = (r / 3) % 4;
        rg  = idx % 3;
        if (!sp)           begin lo = 0; hi = TOT - 1; rtag = "R7"; end
        else if (hw)       begin lo = 0; hi = TOT - 1; rtag = "R10"; end
        else if (idx < VE) begin lo = 0; hi = VE - 1;  rtag = "R8"; end
        else begin
            s = (idx - VE) % NS; lo = VE + s * NW; hi = lo + NW - 1; rtag = "R9";
        end
        mtag = fl ? "R5" : "R3/R4";
        if (gen) mtag = {mtag, " R6"};
        load(r);
        for (int i = lo; i <= hi; i++) begin
            bit hit;
            hit = fl || (m_asid[i] == ca && !m_glob[i]);
            if (gen && m_gid[i] != rg) hit = 0;
            if (hit) m_inv[i] = 1;
        end
        @(negedge clk);
        cfg_split = sp; cfg_hw_walk = hw; cmd_valid = 1; cmd_flush = fl;
        cmd_idx = IW'(idx); cmd_asid = AW'(ca); gid_en = gen; root_gid = GW'(rg);
        @(negedge clk);
        cmd_valid = 0;
        cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            check("R11 done low while busy", int'(done), 0);
            if (cnt == 2) begin
                // R12: command and write arriving mid-walk must be dropped
                cmd_valid = 1; cmd_flush = 1; gid_en = 0; cmd_idx = '0;
                wr_en = 1; wr_idx = '0; wr_asid = AW'(200); wr_glob = 1; wr_gid = GW'(9);
            end
            @(negedge clk);
            cmd_valid = 0; wr_en = 0;
        end
        check({"R11 busy length ", rtag}, cnt, hi - lo + 1);
        check("R11 done pulse", int'(done), 1);
        verify_all({rtag, " ", mtag, " R12"});
        @(negedge clk);
        check("R11 done single", int'(done), 0);
        check("R12 no restart", int'(busy), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        for (int i = 0; i < TOT; i++) begin
            lk_idx = IW'(i); #1;
            check("R1 inv", int'(lk_inv), 1);
            check("R1 asid", int'(lk_asid), 0);
        end
        load(0);
        verify_all("R2");
        for (int sp = 0; sp < 2; sp++)
            for (int hw = 0; hw < 2; hw++)
                for (int idx = 0; idx < (1 << IW); idx++)
                    for (int fl = 0; fl < 2; fl++)
                        run(sp[0], hw[0], idx, fl[0], ((sp * 2 + hw) * 16 + idx) * 2 + fl);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule